// File: doc/BRIEF.md
# Line round-trip delay estimator

This block measures how far the received line frame lags the locally transmitted frame on a 2B1Q U-interface link. It keeps three values. The first is a coarse count of whole symbol periods (12.5 µs each) from the local transmit sync strobe to the received sync strobe. The second is the elastic-store fill level captured when the measurement closes; software adds it to the coarse count. The third is a fine phase: the number of 15.36 MHz reference cycles from a transmit symbol clock edge to the next recovered receive symbol clock edge. One symbol spans 192 reference cycles, so one fine step is about 65.1 ns, which gives a resolution of roughly ±33 ns.

The whole block runs on the reference clock. The symbol clocks and the sync strobes arrive already synchronous to it. A new measurement writes its coarse and elastic fields only when it completes, so a reader never sees a half-built count. If the receive sync never arrives, the counter stops at its limit and the valid flag drops. The fields are read through a one-bit-select register port whose data output is registered.

Top module: `rtd_estimator`

## Requirements
- R1: Reset (synchronous, active high) clears `rd_data`, `dly_valid`, and all three measured fields to zero.
- R2: The coarse field is bits 4:0 of the delay word. It holds the number of `tx_sym_clk` rising edges seen after the `tx_sync` cycle and before the `rx_sync` cycle that closes the measurement.
- R3: The elastic field is bits 7:5 of the delay word. It holds the `elas_fill` value present in the cycle that `rx_sync` closes the measurement.
- R4: The delay word changes only in the cycle after a closing `rx_sync`. Reading during a measurement returns the previous result.
- R5: A transmit symbol edge that arrives while the coarse count is already 31 aborts the measurement. `dly_valid` goes low, the delay word keeps its previous value, and a later `rx_sync` is ignored until the next `tx_sync`.
- R6: `dly_valid` goes high only in the cycle after a closing `rx_sync`.
- R7: A `tx_sync` always restarts the count from zero, even during a measurement or in the same cycle as `rx_sync`. In that case the `rx_sync` does not close anything.
- R8: An `rx_sync` with no measurement open leaves the delay word and `dly_valid` unchanged.
- R9: The phase word holds k mod 192. Here k is the number of reference cycles from a `tx_sym_clk` rising edge to the next `rx_sym_clk` rising edge. Coincident edges give 0.
- R10: An `rx_sym_clk` rising edge with no phase measurement open leaves the phase word unchanged.
- R11: `rd_data` shows the delay word when `rd_sel` was 0 in the previous cycle, and the phase word (zero-extended) when it was 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 15.36 MHz reference clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_sync | input | 1 | Local transmit frame sync strobe, one cycle |
| rx_sync | input | 1 | Received line sync strobe, one cycle |
| tx_sym_clk | input | 1 | Transmit symbol clock level |
| rx_sym_clk | input | 1 | Recovered receive symbol clock level |
| elas_fill | input | 3 | Elastic-store fill indication |
| rd_sel | input | 1 | Register select: 0 delay word, 1 phase word |
| rd_data | output | 8 | Registered read data |
| dly_valid | output | 1 | Last coarse measurement completed |

## Verification
The coarse path is swept over every edge count from 0 to 34, with the elastic fill changing from run to run. This sweep separates the exact count from an off-by-one error, a wrong field position, and a stale fill, and it pushes past the abort point. Separate sequences test a restart mid-measurement, a coincident start and close, a stray receive sync, and a read while a measurement is running. These tell early latching and wrong priority apart from correct holding. The phase path is swept over every spacing from 0 to 199 cycles, so the coincident case and the modulo wrap are both exercised. A lone receive edge then shows whether a stray edge can disturb the held result.

// File: rtl/rtd_pkg.sv
package rtd_pkg;
  localparam int unsigned SYM_REF_CYCLES = 192;
  localparam int unsigned COARSE_BITS    = 5;
  localparam int unsigned ELAS_BITS      = 3;

  typedef enum logic {
    SEL_DELAY = 1'b0,
    SEL_PHASE = 1'b1
  } rd_sel_e;
endpackage

// File: rtl/rtd_edge_detect.sv
module rtd_edge_detect #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] rise
);
  logic [N-1:0] lvl_q;

  always_ff @(posedge clk) begin
    if (rst) lvl_q <= '0;
    else     lvl_q <= lvl;
  end

  for (genvar i = 0; i < N; i++) begin : g_rise
    assign rise[i] = lvl[i] & ~lvl_q[i];
  end
endmodule

// File: rtl/rtd_coarse.sv
module rtd_coarse #(
  parameter int unsigned CW = 5,
  parameter int unsigned EW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tx_sync,
  input  logic          rx_sync,
  input  logic          sym_edge,
  input  logic [EW-1:0] elas_fill,
  output logic [CW-1:0] coarse_q,
  output logic [EW-1:0] elas_q,
  output logic          valid_q
);
  localparam logic [CW-1:0] CMAX = '1;

  logic          busy;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      cnt      <= '0;
      coarse_q <= '0;
      elas_q   <= '0;
      valid_q  <= 1'b0;
    end else if (tx_sync) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (busy) begin
      if (rx_sync) begin
        coarse_q <= cnt;
        elas_q   <= elas_fill;
        valid_q  <= 1'b1;
        busy     <= 1'b0;
      end else if (sym_edge) begin
        if (cnt == CMAX) begin
          busy    <= 1'b0;
          valid_q <= 1'b0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rtd_phase.sv
module rtd_phase #(
  parameter int unsigned MOD = 192,
  parameter int unsigned PW  = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tx_edge,
  input  logic          rx_edge,
  output logic [PW-1:0] phase_q
);
  localparam logic [PW-1:0] LAST = PW'(MOD - 1);

  logic          running;
  logic [PW-1:0] pcnt;
  logic [PW-1:0] pnext;

  assign pnext = (pcnt == LAST) ? '0 : pcnt + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      pcnt    <= '0;
      phase_q <= '0;
    end else if (tx_edge) begin
      pcnt    <= '0;
      running <= ~rx_edge;
      if (rx_edge) phase_q <= '0;
    end else if (running) begin
      if (rx_edge) begin
        phase_q <= pnext;
        running <= 1'b0;
      end else begin
        pcnt <= pnext;
      end
    end
  end
endmodule

// File: rtl/rtd_estimator.sv
module rtd_estimator
  import rtd_pkg::*;
#(
  parameter int unsigned SYM_CYC = rtd_pkg::SYM_REF_CYCLES,
  parameter int unsigned CW      = rtd_pkg::COARSE_BITS,
  parameter int unsigned EW      = rtd_pkg::ELAS_BITS,
  localparam int unsigned PW     = $clog2(SYM_CYC),
  localparam int unsigned DW     = CW + EW,
  localparam int unsigned RW     = (DW > PW) ? DW : PW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tx_sync,
  input  logic          rx_sync,
  input  logic          tx_sym_clk,
  input  logic          rx_sym_clk,
  input  logic [EW-1:0] elas_fill,
  input  logic          rd_sel,
  output logic [RW-1:0] rd_data,
  output logic          dly_valid
);
  logic [1:0]    rises;
  logic [CW-1:0] coarse_q;
  logic [EW-1:0] elas_q;
  logic [DW-1:0] dly_word;
  logic [PW-1:0] phase_word;

  rtd_edge_detect #(.N(2)) u_edges (
    .clk  (clk),
    .rst  (rst),
    .lvl  ({rx_sym_clk, tx_sym_clk}),
    .rise (rises)
  );

  rtd_coarse #(.CW(CW), .EW(EW)) u_coarse (
    .clk       (clk),
    .rst       (rst),
    .tx_sync   (tx_sync),
    .rx_sync   (rx_sync),
    .sym_edge  (rises[0]),
    .elas_fill (elas_fill),
    .coarse_q  (coarse_q),
    .elas_q    (elas_q),
    .valid_q   (dly_valid)
  );

  rtd_phase #(.MOD(SYM_CYC), .PW(PW)) u_phase (
    .clk     (clk),
    .rst     (rst),
    .tx_edge (rises[0]),
    .rx_edge (rises[1]),
    .phase_q (phase_word)
  );

  assign dly_word = {elas_q, coarse_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      case (rd_sel_e'(rd_sel))
        SEL_PHASE: rd_data <= RW'(phase_word);
        default:   rd_data <= RW'(dly_word);
      endcase
    end
  end
endmodule

// File: rtl/rtd_estimator_chk.sv
module rtd_estimator_chk #(
  parameter int unsigned DW = 8,
  parameter int unsigned PW = 8,
  parameter int unsigned RW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          tx_sync,
  input logic          rx_sync,
  input logic          rx_sym_clk,
  input logic          rd_sel,
  input logic [RW-1:0] rd_data,
  input logic          dly_valid,
  input logic [DW-1:0] dly_word,
  input logic [PW-1:0] phase_word
);
  // R4
  delay_held_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rx_sync) |-> $stable(dly_word));

  // R6
  valid_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(dly_valid) |-> $past(rx_sync));

  // R5
  valid_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(dly_valid) |-> $past(!rx_sync && !tx_sync));

  // R10
  phase_held_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rx_sym_clk) |-> $stable(phase_word));

  // R11
  read_delay_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rd_sel) |-> rd_data == RW'($past(dly_word)));

  // R11
  read_phase_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rd_sel) |-> rd_data == RW'($past(phase_word)));
endmodule

bind rtd_estimator rtd_estimator_chk #(.DW(DW), .PW(PW), .RW(RW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .tx_sync    (tx_sync),
  .rx_sync    (rx_sync),
  .rx_sym_clk (rx_sym_clk),
  .rd_sel     (rd_sel),
  .rd_data    (rd_data),
  .dly_valid  (dly_valid),
  .dly_word   (dly_word),
  .phase_word (phase_word)
);

// File: tb/test_rtd_estimator.sv
module test_rtd_estimator;
  localparam int SYM = 192;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tx_sync = 1'b0;
  logic       rx_sync = 1'b0;
  logic       tx_sym_clk = 1'b0;
  logic       rx_sym_clk = 1'b0;
  logic [2:0] elas_fill = '0;
  logic       rd_sel = 1'b0;
  logic [7:0] rd_data;
  logic       dly_valid;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rtd_estimator i_rtd_estimator (
    .clk        (clk),
    .rst        (rst),
    .tx_sync    (tx_sync),
    .rx_sync    (rx_sync),
    .tx_sym_clk (tx_sym_clk),
    .rx_sym_clk (rx_sym_clk),
    .elas_fill  (elas_fill),
    .rd_sel     (rd_sel),
    .rd_data    (rd_data),
    .dly_valid  (dly_valid)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int got, input int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic rd(input logic sel, output int val);
    rd_sel = sel;
    cyc(1);
    val = int'(rd_data);
  endtask

  task automatic sym_edges(input int n);
    for (int i = 0; i < n; i++) begin
      tx_sym_clk = 1'b1; cyc(1);
      tx_sym_clk = 1'b0; cyc(1);
    end
  endtask

  task automatic start_meas();
    tx_sync = 1'b1; cyc(1); tx_sync = 1'b0;
  endtask

  task automatic close_meas(input logic [2:0] fill);
    elas_fill = fill;
    rx_sync = 1'b1; cyc(1); rx_sync = 1'b0;
    elas_fill = ~fill;
    cyc(1);
  endtask

  task automatic phase_run(input int k);
    tx_sym_clk = 1'b1;
    if (k == 0) rx_sym_clk = 1'b1;
    cyc(1);
    tx_sym_clk = 1'b0;
    rx_sym_clk = 1'b0;
    if (k > 0) begin
      cyc(k - 1);
      rx_sym_clk = 1'b1; cyc(1);
      rx_sym_clk = 1'b0;
    end
    cyc(1);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    int v;
    int exp_word;
    int exp_valid;
    cyc(3);
    // R1 reset state
    chk("R1 rd_data", int'(rd_data), 0);
    chk("R1 valid", int'(dly_valid), 0);
    rst = 1'b0;
    cyc(1);
    rd(1'b1, v); chk("R1 phase", v, 0);
    rd(1'b0, v); chk("R1 delay", v, 0);

    exp_word = 0;
    exp_valid = 0;
    // R2 R3 R5 R6 coarse sweep
    for (int n = 0; n <= 34; n++) begin
      logic [2:0] f;
      f = 3'((n * 5 + 3) % 8);
      start_meas();
      sym_edges(n);
      close_meas(f);
      if (n <= 31) begin
        exp_word = (int'(f) << 5) | n;
        exp_valid = 1;
      end else begin
        exp_valid = 0;
      end
      rd(1'b0, v);
      if (n <= 31) chk("R2 R3 delay word", v, exp_word);
      else         chk("R5 word kept after abort", v, exp_word);
      if (n <= 31) chk("R6 valid", int'(dly_valid), exp_valid);
      else         chk("R5 valid low", int'(dly_valid), exp_valid);
    end

    // R4 read during measurement returns previous result
    start_meas();
    sym_edges(9);
    close_meas(3'd6);
    exp_word = (6 << 5) | 9;
    start_meas();
    sym_edges(4);
    rd(1'b0, v); chk("R4 mid-measure read", v, exp_word);
    // R7 restart mid-measurement
    start_meas();
    sym_edges(2);
    close_meas(3'd1);
    exp_word = (1 << 5) | 2;
    rd(1'b0, v); chk("R7 restart count", v, exp_word);

    // R7 coincident start and close
    start_meas();
    sym_edges(3);
    elas_fill = 3'd7;
    tx_sync = 1'b1; rx_sync = 1'b1; cyc(1);
    tx_sync = 1'b0; rx_sync = 1'b0;
    rd(1'b0, v); chk("R7 coincident not closed", v, exp_word);
    sym_edges(1);
    close_meas(3'd4);
    exp_word = (4 << 5) | 1;
    rd(1'b0, v); chk("R7 coincident restart", v, exp_word);

    // R8 stray rx_sync
    close_meas(3'd2);
    rd(1'b0, v); chk("R8 stray rx_sync word", v, exp_word);
    chk("R8 stray rx_sync valid", int'(dly_valid), 1);

    // R9 phase sweep
    for (int k = 0; k < 200; k++) begin
      phase_run(k);
      rd(1'b1, v);
      chk("R9 phase", v, k % SYM);
    end

    // R10 lone rx edge
    phase_run(37);
    rx_sym_clk = 1'b1; cyc(1); rx_sym_clk = 1'b0; cyc(3);
    rd(1'b1, v); chk("R10 lone rx edge", v, 37);

    // R11 select switching
    rd(1'b0, v); chk("R11 sel delay", v, exp_word);
    rd(1'b1, v); chk("R11 sel phase", v, 37);

    done = 1'b1;
    finish_run();
  end
endmodule